// File: doc/BRIEF.md
# Graphics Memory Block-Write Masking Datapath

This block is the write side of a small graphics memory that stores 32-bit column words, each holding four 8-bit pixels (one per byte lane). It supports two kinds of store. A normal write puts the data bus into one column. A block write paints a whole aligned group of eight columns at once from four per-lane color registers. The data bus carries one pixel-enable bit per pixel of the group.

Three masks combine on every bit that is stored:
- a bit-plane mask, loaded by command and enabled per row activation;
- byte-lane mask inputs, which veto a whole lane;
- for block writes, the pixel enables on the data pins.

A masked bit keeps its stored value. A synchronous read port returns a column word one cycle after it is requested, so the contents can be inspected.

Top module: `gram_wpath`

## Requirements
- R1: Command code 1 (load color) stores the data bus into the color registers: color lane i takes data bits [8i+7:8i] and is used only for byte lane i. The color registers change on no other command.
- R2: Command code 2 (load mask) stores the data bus as the bit-plane mask. Where plane masking is on, a mask bit of 1 lets that bit be written and a mask bit of 0 keeps the stored bit.
- R3: Command code 3 (activate) captures the `sf` input. With `sf` low, the plane mask is treated as all ones. With `sf` high, the loaded plane mask applies to both normal writes and block writes.
- R4: Command code 5 (block write) ignores column address bits 2..0 and acts on all eight columns of the aligned group selected by the upper address bits.
- R5: During a block write, data bit 8i+k enables lane i of group column k (k = 0..7). When enabled, the lane receives color lane i under the plane mask. When the bit is low, that pixel keeps its value.
- R6: A high `lane_mask[i]` prevents any change to byte lane i on normal and block writes, whatever the other masks say.
- R7: Command code 4 (normal write) uses the full column address to change exactly one column. It writes the data bus under the plane and lane masks, and every other column is unchanged.
- R8: After reset the color registers and plane mask are zero, plane masking is off, and `rd_data` is zero.
- R9: With `rd_en` high, `rd_data` shows the addressed column word after the next clock edge. With `rd_en` low, `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | 0 idle, 1 load color, 2 load mask, 3 activate, 4 normal write, 5 block write |
| sf | input | 1 | Special-function flag, sampled on activate |
| col_addr | input | 6 | Column address |
| din | input | 32 | Data bus / colors / mask / pixel enables |
| lane_mask | input | 4 | Per-byte-lane write block, active high |
| rd_en | input | 1 | Read request |
| rd_addr | input | 6 | Read column address |
| rd_data | output | 32 | Read word, one cycle after request |

## Verification
The assertions assume that `cmd` only carries codes 0 to 5 and that `sf` matters only on an activate cycle. The stimulus keeps to this: commands are drawn from the legal set only, and `sf` is randomised on every cycle so that any stray sampling would show up in the plane-mask behaviour. Reads are issued only in idle cycles. Because of this, the bench never depends on read-during-write ordering, which the assertions do not describe.

// File: rtl/gram_wpath.sv
module gram_wpath #(
  parameter int LANES = 4,
  parameter int PIX   = 8,
  parameter int COLS  = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             cmd,
  input  logic                   sf,
  input  logic [$clog2(COLS)-1:0] col_addr,
  input  logic [LANES*PIX-1:0]   din,
  input  logic [LANES-1:0]       lane_mask,
  input  logic                   rd_en,
  input  logic [$clog2(COLS)-1:0] rd_addr,
  output logic [LANES*PIX-1:0]   rd_data
);
  localparam int W  = LANES*PIX;
  localparam int AW = $clog2(COLS);
  localparam int GB = $clog2(PIX);
  localparam logic [2:0] C_LCOL = 3'd1, C_LMSK = 3'd2, C_ACT = 3'd3,
                         C_WR = 3'd4, C_BWR = 3'd5;

  logic [W-1:0] color_q, mask_q;
  logic         wpb_q;
  logic [W-1:0] mem [COLS];

  wire [W-1:0] pmask = wpb_q ? mask_q : {W{1'b1}};

  logic [W-1:0] nmask;
  logic [W-1:0] bmask [PIX];

  always_comb begin
    for (int i = 0; i < LANES; i++)
      nmask[i*PIX +: PIX] = lane_mask[i] ? '0 : pmask[i*PIX +: PIX];
    for (int k = 0; k < PIX; k++)
      for (int i = 0; i < LANES; i++)
        bmask[k][i*PIX +: PIX] = (din[i*PIX + k] && !lane_mask[i]) ? pmask[i*PIX +: PIX] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      color_q <= '0;
      mask_q  <= '0;
      wpb_q   <= 1'b0;
    end else begin
      if (cmd == C_LCOL) color_q <= din;
      if (cmd == C_LMSK) mask_q  <= din;
      if (cmd == C_ACT)  wpb_q   <= sf;
    end
  end

  always_ff @(posedge clk) begin
    if (cmd == C_WR)
      mem[col_addr] <= (mem[col_addr] & ~nmask) | (din & nmask);
    else if (cmd == C_BWR)
      for (int k = 0; k < PIX; k++) begin
        logic [AW-1:0] idx;
        idx = {col_addr[AW-1:GB], GB'(k)};
        mem[idx] <= (mem[idx] & ~bmask[k]) | (color_q & bmask[k]);
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/gram_wpath_chk.sv
module gram_wpath_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   cmd,
  input logic         sf,
  input logic [W-1:0] din,
  input logic         rd_en,
  input logic [W-1:0] rd_data,
  input logic [W-1:0] color_q,
  input logic [W-1:0] mask_q,
  input logic         wpb_q
);
  p_color_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 3'd1 |=> color_q == $past(din));
  p_color_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd != 3'd1 |=> $stable(color_q));
  p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 3'd2 |=> mask_q == $past(din));
  p_flag_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 3'd3 |=> wpb_q == $past(sf));
  p_flag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd != 3'd3 |=> $stable(wpb_q));
  p_rd_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rd_data == '0);
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind gram_wpath gram_wpath_chk #(.W(LANES*PIX)) u_chk (.*);

// File: tb/gram_wpath_test.sv
`timescale 1ns/1ps
module gram_wpath_test;
  logic        clk = 0, rst_n = 0;
  logic [2:0]  cmd = 0;
  logic        sf = 0, rd_en = 0;
  logic [5:0]  col_addr = 0, rd_addr = 0;
  logic [31:0] din = 0;
  logic [3:0]  lane_mask = 0;
  logic [31:0] rd_data;

  gram_wpath uut (.clk, .rst_n, .cmd, .sf, .col_addr, .din, .lane_mask,
                  .rd_en, .rd_addr, .rd_data);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] m_mem [64];
  logic [31:0] m_color = 0, m_mask = 0;
  logic        m_wpb = 0;

  function automatic logic [31:0] plane();
    return m_wpb ? m_mask : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [31:0] m);
    return (old & ~m) | (nw & m);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] c, logic [5:0] a, logic [31:0] d, logic [3:0] lm, logic f);
    logic [31:0] m;
    @(negedge clk);
    cmd = c; col_addr = a; din = d; lane_mask = lm; sf = f; rd_en = 0;
    case (c)
      3'd1: m_color = d;
      3'd2: m_mask = d;
      3'd3: m_wpb = f;
      3'd4: begin
        for (int i = 0; i < 4; i++) m[i*8 +: 8] = lm[i] ? 8'h00 : plane() >> (i*8);
        m_mem[a] = merge(m_mem[a], d, m);
      end
      3'd5: for (int k = 0; k < 8; k++) begin
        for (int i = 0; i < 4; i++)
          m[i*8 +: 8] = (d[i*8+k] && !lm[i]) ? plane() >> (i*8) : 8'h00;
        m_mem[{a[5:3], 3'(k)}] = merge(m_mem[{a[5:3], 3'(k)}], m_color, m);
      end
      default: ;
    endcase
  endtask

  task automatic read_chk(logic [5:0] a, string tag);
    @(negedge clk);
    cmd = 0; sf = $urandom; rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
    check(tag, rd_data, m_mem[a]);
  endtask

  task automatic scan(string tag);
    for (int a = 0; a < 64; a++) read_chk(6'(a), tag);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R8 rd_data reset", rd_data, 32'h0);
    rst_n = 1;
    // R8: registers zero -> block write with flag low writes zeros
    for (int a = 0; a < 64; a++) issue(4, 6'(a), $urandom, 0, 0);
    issue(5, 6'd16, 32'hFFFF_FFFF, 4'h0, 0);
    scan("R8 zero color after reset");
    // R9: hold without rd_en
    read_chk(6'd5, "R9 read");
    held = rd_data;
    issue(4, 6'd5, ~m_mem[5], 0, 0);
    @(negedge clk);
    check("R9 hold when rd_en low", rd_data, held);
    read_chk(6'd5, "R9 read after write");
    // Worked example: colors, mask, flag high, pixel enables, lane 0 blocked
    issue(1, 0, 32'hC3E1_0FA3, 0, 0);
    issue(2, 0, 32'hFFDD_4276, 0, 0);
    issue(3, 0, 0, 0, 1);
    issue(5, 6'd42, 32'h77FF_55EE, 4'b0001, 0);
    scan("R5 example block write");
    // R3: flag low ignores loaded mask
    issue(3, 0, 0, 0, 0);
    issue(4, 6'd9, 32'hA5A5_5A5A, 0, 1);
    read_chk(6'd9, "R3 plane mask off");
    // R2/R3: flag high, normal write under mask
    issue(2, 0, 32'h0F0F_F0F0, 0, 0);
    issue(3, 0, 0, 0, 1);
    issue(4, 6'd9, 32'hFFFF_FFFF, 0, 0);
    read_chk(6'd9, "R2 plane mask normal write");
    // R6: all lanes blocked
    issue(4, 6'd10, ~m_mem[10], 4'hF, 0);
    read_chk(6'd10, "R6 lanes blocked normal write");
    issue(5, 6'd0, 32'hFFFF_FFFF, 4'hF, 0);
    scan("R6 lanes blocked block write");
    // R4: nonzero low address bits on block write
    issue(1, 0, 32'h1234_5678, 0, 0);
    issue(5, 6'd63, 32'hFFFF_FFFF, 0, 0);
    scan("R4 aligned group");
    // R7 / R1: random mix
    for (int r = 0; r < 4; r++) begin
      for (int n = 0; n < 300; n++) begin
        logic [2:0] c;
        c = 3'(1 + $urandom_range(0, 4));
        issue(c, 6'($urandom), $urandom, 4'($urandom), 1'($urandom));
      end
      scan("R7 random mix");
    end
    @(negedge clk);
    cmd = 0;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule